// File: doc/BRIEF.md
# Four-SIMD Wavefront Issue Sequencer

This block decides, for one compute unit with four 16-lane SIMD units, which resident wavefront starts its next vector instruction and how that instruction is spread across time. Each SIMD owns a table of ten wavefront slots. Every slot holds a valid flag, a program counter and a 64-bit execution mask. A wavefront is always 64 work-items wide. A single vector instruction therefore occupies its SIMD for four back-to-back cycles, and each cycle covers one group of 16 work-items.

A rotation pointer gives one SIMD an issue opportunity per cycle. With four SIMDs and a four-cycle instruction, every SIMD gets a new slot exactly when its previous instruction finishes. Inside a SIMD, a round-robin picker selects a valid, non-stalled wavefront. The search starts after the wavefront that issued last. If no wavefront can go, the slot becomes a bubble. For each SIMD the block drives the wavefront id, the PC, the quarter index and a 16-bit lane enable. Work-items added only to pad a short workgroup are masked off through the lane enable.

Wavefronts enter through an allocate port and leave through a retire port. Instruction fetch, decode, register files and ALUs are outside this block.

Top module: `wave_issue_seq`

## Requirements
- R1: The issue rotation starts at SIMD 0 on the first clock edge after reset and advances by one SIMD per cycle, wrapping from 3 to 0. An instruction can start on SIMD s only at an edge where the rotation points at s.
- R2: An issued instruction is presented for four consecutive cycles with quarter index 0, 1, 2 and 3 in that order. The wavefront id and the PC are held for all four cycles.
- R3: In any cycle, at most one SIMD shows the start of an instruction (valid with quarter 0). Each SIMD starts at most one instruction in any four-cycle window.
- R4: Within a SIMD, the issuing wavefront is the first ready slot in circular order after the slot that issued last on that SIMD. After reset the search begins at slot 0.
- R5: The PC presented is the wavefront's PC at the moment of issue. That wavefront's stored PC then increments by one.
- R6: During quarter q, the lane enable of a SIMD equals mask bits [16q+15:16q] of the issuing wavefront, captured at issue. Padded work-items whose mask bits are zero therefore never get an enabled lane.
- R7: A slot is ready only when it is valid and its stall bit, stall[s*10+k], is low. When no slot of the SIMD is ready at its turn, the SIMD is idle for four cycles: valid low, quarter 0 and lane enable zero.
- R8: An allocate request is accepted only if the slot index is below 10 and that slot is free. The request then loads the start PC and the mask. Any other request, including one into a SIMD whose ten slots are all in use, changes nothing and raises alloc_err for exactly the cycle after the request.
- R9: A retire request clears the slot's valid flag. The retired wavefront is not issued again until it is allocated anew.
- R10: Synchronous reset clears all valid flags, all SIMD outputs and alloc_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Allocate request |
| alloc_simd | input | 2 | Target SIMD of the allocate request |
| alloc_slot | input | 4 | Target slot of the allocate request |
| alloc_pc | input | 16 | Start PC of the new wavefront |
| alloc_mask | input | 64 | Execution mask of the new wavefront |
| alloc_err | output | 1 | Previous allocate request was rejected |
| ret_valid | input | 1 | Retire request |
| ret_simd | input | 2 | SIMD of the retired wavefront |
| ret_slot | input | 4 | Slot of the retired wavefront |
| stall | input | 40 | Per-wavefront stall, bit s*10+k |
| ex_valid | output | 4 | SIMD s is executing an instruction |
| ex_wf | output | 16 | Slot id per SIMD, 4 bits each |
| ex_pc | output | 64 | Instruction PC per SIMD, 16 bits each |
| ex_quarter | output | 8 | Quarter index per SIMD, 2 bits each |
| ex_lane_en | output | 64 | Lane enables per SIMD, 16 bits each |

## Verification
The properties assume that stall, allocate and retire inputs settle between edges. They do not assume that slot or SIMD indices lie in range, because out-of-range slots are a legal, rejected case. The quarter-step and single-start properties rely on the rotation length equalling the number of quarters. This holds for the default parameters and for any setting with as many SIMDs as 16-lane quarters.

The stimulus stays within these assumptions by driving every input one time unit after the rising edge. Random allocate slots range up to 11 so that rejections occur. Allocate and retire requests that hit the same slot in the same cycle are allowed; both the design and the bench model resolve them from the state before the edge.

// File: rtl/cu_seq_pkg.sv
package cu_seq_pkg;
    localparam int CU_SIMDS   = 4;
    localparam int SIMD_LANES = 16;
    localparam int WAVE_ITEMS = 64;
    localparam int SIMD_SLOTS = 10;
    localparam int PC_BITS    = 16;
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
    parameter int SL = 10,
    localparam int IW = $clog2(SL)
) (
    input  logic [SL-1:0] ready,
    input  logic [IW-1:0] last,
    output logic          found,
    output logic [IW-1:0] idx
);
    // circular search beginning one past the previous winner
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 1; i <= SL; i++) begin
            if (!found && ready[(int'(last) + i) % SL]) begin
                found = 1'b1;
                idx   = IW'((int'(last) + i) % SL);
            end
        end
    end
endmodule

// File: rtl/quarter_slice.sv
module quarter_slice #(
    parameter int LANES = 16,
    parameter int WAVE  = 64,
    localparam int QW   = $clog2(WAVE / LANES)
) (
    input  logic            act,
    input  logic [QW-1:0]   qtr,
    input  logic [WAVE-1:0] mask,
    output logic [LANES-1:0] en
);
    always_comb en = act ? mask[int'(qtr) * LANES +: LANES] : '0;
endmodule

// File: rtl/wave_issue_seq.sv
module wave_issue_seq
    import cu_seq_pkg::*;
#(
    parameter int NS    = CU_SIMDS,
    parameter int LANES = SIMD_LANES,
    parameter int WAVE  = WAVE_ITEMS,
    parameter int SL    = SIMD_SLOTS,
    parameter int PC_W  = PC_BITS,
    localparam int QN   = WAVE / LANES,
    localparam int QW   = $clog2(QN),
    localparam int IW   = $clog2(SL),
    localparam int SW   = $clog2(NS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  alloc_valid,
    input  logic [SW-1:0]         alloc_simd,
    input  logic [IW-1:0]         alloc_slot,
    input  logic [PC_W-1:0]       alloc_pc,
    input  logic [WAVE-1:0]       alloc_mask,
    output logic                  alloc_err,
    input  logic                  ret_valid,
    input  logic [SW-1:0]         ret_simd,
    input  logic [IW-1:0]         ret_slot,
    input  logic [NS*SL-1:0]      stall,
    output logic [NS-1:0]         ex_valid,
    output logic [NS*IW-1:0]      ex_wf,
    output logic [NS*PC_W-1:0]    ex_pc,
    output logic [NS*QW-1:0]      ex_quarter,
    output logic [NS*LANES-1:0]   ex_lane_en
);
    typedef struct packed {
        logic [SW-1:0]                    rot;
        logic [NS-1:0][SL-1:0]            vld;
        logic [NS-1:0][SL-1:0][PC_W-1:0]  pc;
        logic [NS-1:0][SL-1:0][WAVE-1:0]  mask;
        logic [NS-1:0][IW-1:0]            last;
        logic [NS-1:0]                    act;
        logic [NS-1:0][IW-1:0]            wf;
        logic [NS-1:0][PC_W-1:0]          xpc;
        logic [NS-1:0][QW-1:0]            qtr;
        logic [NS-1:0][WAVE-1:0]          xmask;
        logic                             err;
    } seq_state_t;

    seq_state_t st_q, st_d;

    logic [NS-1:0]         found;
    logic [NS-1:0][IW-1:0] pick;

    for (genvar s = 0; s < NS; s++) begin : g_simd
        logic [SL-1:0] ready;
        assign ready = st_q.vld[s] & ~stall[s*SL +: SL];

        rr_pick #(.SL(SL)) u_pick (
            .ready (ready),
            .last  (st_q.last[s]),
            .found (found[s]),
            .idx   (pick[s])
        );

        quarter_slice #(.LANES(LANES), .WAVE(WAVE)) u_slice (
            .act  (st_q.act[s]),
            .qtr  (st_q.qtr[s]),
            .mask (st_q.xmask[s]),
            .en   (ex_lane_en[s*LANES +: LANES])
        );

        assign ex_valid[s]              = st_q.act[s];
        assign ex_wf[s*IW +: IW]        = st_q.wf[s];
        assign ex_pc[s*PC_W +: PC_W]    = st_q.xpc[s];
        assign ex_quarter[s*QW +: QW]   = st_q.qtr[s];
    end

    assign alloc_err = st_q.err;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        st_d.rot = (int'(st_q.rot) == NS - 1) ? '0 : st_q.rot + 1'b1;

        for (int s = 0; s < NS; s++) begin
            if (st_q.rot == SW'(s)) begin
                st_d.qtr[s] = '0;
                st_d.act[s] = found[s];
                if (found[s]) begin
                    st_d.wf[s]          = pick[s];
                    st_d.xpc[s]         = st_q.pc[s][pick[s]];
                    st_d.xmask[s]       = st_q.mask[s][pick[s]];
                    st_d.pc[s][pick[s]] = st_q.pc[s][pick[s]] + 1'b1;
                    st_d.last[s]        = pick[s];
                end
            end else if (st_q.act[s]) begin
                st_d.qtr[s] = st_q.qtr[s] + 1'b1;
            end
        end

        if (ret_valid && int'(ret_slot) < SL)
            st_d.vld[ret_simd][ret_slot] = 1'b0;

        if (alloc_valid) begin
            if (int'(alloc_slot) < SL) begin
                if (!st_q.vld[alloc_simd][alloc_slot]) begin
                    st_d.vld[alloc_simd][alloc_slot]  = 1'b1;
                    st_d.pc[alloc_simd][alloc_slot]   = alloc_pc;
                    st_d.mask[alloc_simd][alloc_slot] = alloc_mask;
                end else begin
                    st_d.err = 1'b1;
                end
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            for (int s = 0; s < NS; s++) st_q.last[s] <= IW'(SL - 1);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wave_issue_chk.sv
module wave_issue_chk #(
    parameter int NS    = 4,
    parameter int SL    = 10,
    parameter int PC_W  = 16,
    parameter int QW    = 2,
    parameter int IW    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               alloc_valid,
    input logic [IW-1:0]      alloc_slot,
    input logic               alloc_err,
    input logic [NS-1:0]      ex_valid,
    input logic [NS*IW-1:0]   ex_wf,
    input logic [NS*PC_W-1:0] ex_pc,
    input logic [NS*QW-1:0]   ex_quarter
);
    logic [NS-1:0] starts;

    for (genvar s = 0; s < NS; s++) begin : g_chk
        assign starts[s] = ex_valid[s] && (ex_quarter[s*QW +: QW] == '0);

        AST_QUARTER_STEP: assert property (@(posedge clk) disable iff (rst)
            (ex_valid[s] && ex_quarter[s*QW +: QW] != '1) |=>
            (ex_valid[s] && ex_quarter[s*QW +: QW] == $past(ex_quarter[s*QW +: QW]) + 1'b1
             && $stable(ex_wf[s*IW +: IW]) && $stable(ex_pc[s*PC_W +: PC_W]))); // R2
    end

    AST_SINGLE_START: assert property (@(posedge clk) disable iff (rst)
        $countones(starts) <= 1); // R3

    AST_BAD_SLOT_ERR: assert property (@(posedge clk) disable iff (rst)
        (alloc_valid && int'(alloc_slot) >= SL) |=> alloc_err); // R8

    AST_ERR_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        alloc_err |-> $past(alloc_valid)); // R8

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ex_valid == '0 && !alloc_err)); // R10
endmodule

bind wave_issue_seq wave_issue_chk #(
    .NS(NS), .SL(SL), .PC_W(PC_W), .QW(QW), .IW(IW)
) u_chk (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_slot(alloc_slot),
    .alloc_err(alloc_err), .ex_valid(ex_valid), .ex_wf(ex_wf), .ex_pc(ex_pc),
    .ex_quarter(ex_quarter)
);

// File: tb/sim_wave_issue_seq.sv
module sim_wave_issue_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alloc_valid = 1'b0;
    logic [1:0]  alloc_simd = '0;
    logic [3:0]  alloc_slot = '0;
    logic [15:0] alloc_pc = '0;
    logic [63:0] alloc_mask = '0;
    logic        alloc_err;
    logic        ret_valid = 1'b0;
    logic [1:0]  ret_simd = '0;
    logic [3:0]  ret_slot = '0;
    logic [39:0] stall = '0;
    logic [3:0]  ex_valid;
    logic [15:0] ex_wf;
    logic [63:0] ex_pc;
    logic [7:0]  ex_quarter;
    logic [63:0] ex_lane_en;

    always #5 clk = ~clk;

    wave_issue_seq u0 (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_simd(alloc_simd),
        .alloc_slot(alloc_slot), .alloc_pc(alloc_pc), .alloc_mask(alloc_mask),
        .alloc_err(alloc_err), .ret_valid(ret_valid), .ret_simd(ret_simd),
        .ret_slot(ret_slot), .stall(stall), .ex_valid(ex_valid), .ex_wf(ex_wf),
        .ex_pc(ex_pc), .ex_quarter(ex_quarter), .ex_lane_en(ex_lane_en)
    );

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit          mv   [4][10];
    logic [15:0] mpc  [4][10];
    logic [63:0] mmk  [4][10];
    int          mlast[4];
    int          mrot;
    bit          oact [4];
    int          owf  [4];
    logic [15:0] opc  [4];
    int          oqtr [4];
    logic [63:0] omk  [4];
    bit          oerr;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 10; k++) begin mv[s][k] = 0; mpc[s][k] = 0; mmk[s][k] = 0; end
            mlast[s] = 9; oact[s] = 0; owf[s] = 0; opc[s] = 0; oqtr[s] = 0; omk[s] = 0;
        end
        mrot = 0; oerr = 0;
    endtask

    task automatic model_next();
        bit acc;
        for (int s = 0; s < 4; s++) begin
            if (s == mrot) begin
                bit got = 0;
                oqtr[s] = 0;
                for (int i = 1; i <= 10; i++) begin
                    int k = (mlast[s] + i) % 10;
                    if (!got && mv[s][k] && !stall[s*10+k]) begin
                        got = 1; owf[s] = k; opc[s] = mpc[s][k]; omk[s] = mmk[s][k];
                        mpc[s][k] = mpc[s][k] + 16'd1; mlast[s] = k;
                    end
                end
                oact[s] = got;
            end else if (oact[s]) begin
                oqtr[s] = oqtr[s] + 1;
            end
        end
        mrot = (mrot + 1) % 4;
        acc = alloc_valid && alloc_slot < 10 && !mv[alloc_simd][alloc_slot];
        oerr = alloc_valid && !acc;
        if (ret_valid && ret_slot < 10) mv[ret_simd][ret_slot] = 0;
        if (acc) begin
            mv[alloc_simd][alloc_slot]  = 1;
            mpc[alloc_simd][alloc_slot] = alloc_pc;
            mmk[alloc_simd][alloc_slot] = alloc_mask;
        end
    endtask

    task automatic compare();
        for (int s = 0; s < 4; s++) begin
            logic [15:0] exp_en;
            exp_en = oact[s] ? omk[s][oqtr[s]*16 +: 16] : 16'h0;
            chk(ex_valid[s] == oact[s], oact[s] ? "R1" : "R7", "valid", ex_valid[s], oact[s]);
            chk(ex_quarter[s*2 +: 2] == 2'(oqtr[s]), "R2", "quarter", ex_quarter[s*2 +: 2], oqtr[s]);
            chk(ex_lane_en[s*16 +: 16] == exp_en, "R6", "lane_en", ex_lane_en[s*16 +: 16], exp_en);
            if (oact[s]) begin
                chk(ex_wf[s*4 +: 4] == 4'(owf[s]), "R4", "wf", ex_wf[s*4 +: 4], owf[s]);
                chk(ex_pc[s*16 +: 16] == opc[s], "R5", "pc", ex_pc[s*16 +: 16], opc[s]);
            end
        end
        chk(alloc_err == oerr, "R8", "alloc_err", alloc_err, oerr);
    endtask

    task automatic step();
        model_next();
        @(posedge clk); #1;
        compare();
        alloc_valid = 0; ret_valid = 0;
    endtask

    task automatic do_alloc(int s, int k, logic [15:0] pc, logic [63:0] mk);
        alloc_valid = 1; alloc_simd = 2'(s); alloc_slot = 4'(k); alloc_pc = pc; alloc_mask = mk;
        step();
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R10: outputs cleared under reset
        chk(ex_valid == 0 && ex_lane_en == 0 && !alloc_err, "R10", "reset outputs",
            {ex_valid, alloc_err}, 0);
        rst = 0;

        // fill SIMD 0; slot 1 carries a padded 20-item mask (R6)
        for (int k = 0; k < 10; k++)
            do_alloc(0, k, 16'(100 + 10*k), (k == 1) ? 64'h0000_0000_000F_FFFF : '1);
        do_alloc(0, 3, 16'h0, '1);   // R8: SIMD full, slot occupied
        do_alloc(0, 12, 16'h0, '1);  // R8: slot out of range
        do_alloc(2, 5, 16'h2000, 64'hF0F0_0000_FFFF_1234);
        repeat (40) step();          // R4 R5 rotation through slots

        stall[9:0] = '1;             // R7: all of SIMD 0 stalled
        repeat (8) step();
        stall = '0;
        for (int k = 0; k < 10; k++) begin
            ret_valid = 1; ret_simd = 0; ret_slot = 4'(k);   // R9
            step();
        end
        repeat (8) step();

        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 9) < 3) begin
                alloc_valid = 1; alloc_simd = 2'($urandom_range(0, 3));
                alloc_slot = 4'($urandom_range(0, 11)); alloc_pc = 16'($urandom);
                alloc_mask = {$urandom, $urandom};
                if ($urandom_range(0, 3) == 0) alloc_mask[63:32] = '0;
            end
            if ($urandom_range(0, 9) == 0) begin
                ret_valid = 1; ret_simd = 2'($urandom_range(0, 3));
                ret_slot = 4'($urandom_range(0, 10));
            end
            stall = {$urandom, $urandom} & {$urandom, $urandom};
            step();
        end
        finish_run();
    end
endmodule